// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences one 10-bit successive-approximation conversion at a time. Software sets a start bit. The block then holds the sampled input and walks a trial code from the most significant bit to the least significant bit against one comparator decision per period. When it finishes, it loads the result, drops the start bit and raises a sticky completion flag. The analog parts are outside the block: the sample switch, the DAC and the comparator. They are reached through a hold output, a trial-code output and a comparator input.

The conversion period (one TAD) comes from one of two sources. The first is a power-of-two divide of the system clock, chosen by a 3-bit select whose codes are not in ascending order. The second is the rising edges of a slow external RC clock, passed through a two-flop synchronizer. A conversion always spans eleven periods. Software can abort a conversion by clearing the start bit. An abort leaves the last good result in place and forces a two-period recovery. Only after that recovery does the input start sampling again.

Top module: `sar_seq`

## Requirements
- R1: After reset, go_o, hold_o, acq_o, flag_o and irq_o are 0. The result reads 0 and trial_o reads 10'h200.
- R2: clk_sel_i picks the TAD length from the index {sel[1:0],sel[2]}, giving 2 << index system clocks. The codes map as 000=2, 100=4, 001=8, 101=16, 010=32 and 110=64. A conversion holds go_o high for exactly 11 TAD. Any code with sel[1:0]=11 instead takes one TAD per rising edge of rc_clk_i, as seen after a two-flop synchronizer.
- R3: A control write with ctrl_en_i=1 and ctrl_go_i=1 starts a conversion when the module is already enabled and idle. From the next cycle, go_o=1, hold_o=1, acq_o=0 and trial_o=10'h200.
- R4: A control write that turns the module on (previously disabled) while setting ctrl_go_i does not start a conversion.
- R5: TAD 1 only holds. At the end of each of TADs 2 to 11, comp_i=1 keeps the current trial bit and comp_i=0 clears it, and the next lower bit is set. Bit 9 is decided first and bit 0 last.
- R6: At the end of the 11th TAD, the final code is loaded into the result, go_o and hold_o fall, flag_o is set and acq_o returns to 1.
- R7: res_hi_o carries result bits 9:8 and res_lo_o carries bits 7:0, right-justified.
- R8: flag_o stays set until a flag_clr_i pulse; when completion and clear coincide, completion wins. irq_o is flag_o AND irq_en_i.
- R9: A control write with ctrl_en_i=1 and ctrl_go_i=0 during a conversion aborts it. go_o falls the next cycle, and the result and flag keep their values.
- R10: After an abort, acq_o stays 0 for 2 TAD and start writes are ignored; then acq_o returns to 1.
- R11: A control write with ctrl_en_i=0 stops any conversion or recovery at once without loading the result, and keeps acq_o at 0.
- R12: The clock select is captured at start; changing clk_sel_i during a conversion does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_clk_i | input | 1 | Slow external RC clock, asynchronous |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_en_i | input | 1 | Module-on value written with the strobe |
| ctrl_go_i | input | 1 | Start bit value written with the strobe |
| clk_sel_i | input | 3 | Conversion clock select code |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clear pulse for the completion flag |
| comp_i | input | 1 | Comparator: 1 when the input is at or above trial_o |
| go_o | output | 1 | Start bit read-back, high while converting |
| acq_o | output | 1 | Sample path connected (enabled, idle) |
| hold_o | output | 1 | Sampling capacitor disconnected |
| trial_o | output | 10 | Trial code to the DAC |
| res_hi_o | output | 2 | Result bits 9:8 |
| res_lo_o | output | 8 | Result bits 7:0 |
| flag_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong TAD count or prescaler state shows as go_o falling a cycle early or late. It also shifts every trial_o step, which the per-cycle comparison catches within one TAD. A corrupted trial pointer produces a wrong trial_o on the next decision edge and a result different from the analog value the bench models. A broken abort or recovery path shows up as a result or flag change right after the abort write, or as acq_o returning before two periods have elapsed.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int SEL_W = 3;
  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_RECOV} sar_state_e;
endpackage

// File: rtl/sar_tad_gen.sv
module sar_tad_gen
  import sar_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rc_clk_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             run_i,
  input  logic             clr_i,
  output logic             tick_o
);
  logic [SYNC_N:0]      sync_q, sync_d;
  logic [DIV_W-1:0]     cnt_q, cnt_d, lim;
  logic [SEL_W-1:0]     idx;
  logic                 use_rc, rc_edge, wrap;

  always_comb begin
    idx     = {sel_i[1:0], sel_i[2]};
    use_rc  = &sel_i[1:0];
    // 2 << idx wraps to zero for the largest ratio, so minus one gives all ones
    lim     = (DIV_W'(2) << idx) - DIV_W'(1);
    wrap    = (cnt_q == lim);
    rc_edge = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];
    sync_d  = {sync_q[SYNC_N-1:0], rc_clk_i};
    if (clr_i)      cnt_d = '0;
    else if (run_i) cnt_d = wrap ? '0 : cnt_q + DIV_W'(1);
    else            cnt_d = cnt_q;
    tick_o  = run_i & ~clr_i & (use_rc ? rc_edge : wrap);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int N_TAD   = 11,
  parameter int REC_TAD = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic       en_d_i,
  input  logic       go_d_i,
  input  logic       tick_i,
  output logic       en_o,
  output sar_state_e state_o,
  output logic       start_o,
  output logic       abort_o,
  output logic       decide_o,
  output logic       done_o,
  output logic       clr_o
);
  localparam int TAD_W = $clog2(N_TAD);

  sar_state_e       st_q, st_d;
  logic [TAD_W-1:0] tad_q, tad_d;
  logic             en_q, en_d, kill;

  always_comb begin
    kill     = wr_i & ~en_d_i;
    start_o  = wr_i & en_d_i & go_d_i & en_q & (st_q == ST_IDLE);
    abort_o  = wr_i & en_d_i & ~go_d_i & (st_q == ST_CONV);
    clr_o    = start_o | abort_o | kill;
    decide_o = tick_i & ~clr_o & (st_q == ST_CONV) & (tad_q != '0);
    done_o   = tick_i & ~clr_o & (st_q == ST_CONV) & (tad_q == TAD_W'(N_TAD-1));
    en_d     = wr_i ? en_d_i : en_q;
    st_d     = st_q;
    tad_d    = tad_q;
    if (kill) begin
      st_d = ST_IDLE;
    end else if (abort_o) begin
      st_d  = ST_RECOV;
      tad_d = '0;
    end else if (start_o) begin
      st_d  = ST_CONV;
      tad_d = '0;
    end else if (tick_i) begin
      if (st_q == ST_CONV) begin
        if (done_o) st_d  = ST_IDLE;
        else        tad_d = tad_q + TAD_W'(1);
      end else if (st_q == ST_RECOV) begin
        if (tad_q == TAD_W'(REC_TAD-1)) st_d  = ST_IDLE;
        else                            tad_d = tad_q + TAD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tad_q <= '0;
      en_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      tad_q <= tad_d;
      en_q  <= en_d;
    end
  end

  assign en_o    = en_q;
  assign state_o = st_q;
endmodule

// File: rtl/sar_sar.sv
module sar_sar #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             decide_i,
  input  logic             load_i,
  input  logic             comp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] res_o
);
  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] trial_q, trial_d, ptr_q, ptr_d, res_q, res_d, kept;

  always_comb begin
    kept    = comp_i ? trial_q : (trial_q & ~ptr_q);
    trial_d = trial_q;
    ptr_d   = ptr_q;
    if (start_i) begin
      trial_d = MSB;
      ptr_d   = MSB;
    end else if (decide_i) begin
      trial_d = kept | (ptr_q >> 1);
      ptr_d   = ptr_q >> 1;
    end
    res_d = load_i ? trial_d : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= MSB;
      ptr_q   <= MSB;
      res_q   <= '0;
    end else begin
      trial_q <= trial_d;
      ptr_q   <= ptr_d;
      res_q   <= res_d;
    end
  end

  assign trial_o = trial_q;
  assign res_o   = res_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES_W   = 10,
  parameter int LO_W    = 8,
  parameter int N_TAD   = RES_W + 1,
  parameter int REC_TAD = 2,
  parameter int DIV_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rc_clk_i,
  input  logic             ctrl_wr_i,
  input  logic             ctrl_en_i,
  input  logic             ctrl_go_i,
  input  logic [SEL_W-1:0] clk_sel_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  input  logic             comp_i,
  output logic             go_o,
  output logic             acq_o,
  output logic             hold_o,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-LO_W-1:0] res_hi_o,
  output logic [LO_W-1:0]  res_lo_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             flag_q, flag_d, en_q;
  logic             start, abort, decide, done, clr, tick;
  logic [RES_W-1:0] res;
  sar_state_e       state;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  sar_ctrl #(.N_TAD(N_TAD), .REC_TAD(REC_TAD)) u_ctrl (
    .clk(clk), .rst_n(rst_ni), .wr_i(ctrl_wr_i), .en_d_i(ctrl_en_i),
    .go_d_i(ctrl_go_i), .tick_i(tick), .en_o(en_q), .state_o(state),
    .start_o(start), .abort_o(abort), .decide_o(decide), .done_o(done),
    .clr_o(clr)
  );

  sar_tad_gen #(.DIV_W(DIV_W), .SYNC_N(2)) u_tad (
    .clk(clk), .rst_n(rst_ni), .rc_clk_i(rc_clk_i), .sel_i(sel_q),
    .run_i(state != ST_IDLE), .clr_i(clr), .tick_o(tick)
  );

  sar_sar #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_ni), .start_i(start), .decide_i(decide),
    .load_i(done), .comp_i(comp_i), .trial_o(trial_o), .res_o(res)
  );

  always_comb begin
    sel_d  = start ? clk_sel_i : sel_q;
    flag_d = done ? 1'b1 : (flag_clr_i ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      flag_q <= flag_d;
    end
  end

  assign go_o     = (state == ST_CONV);
  assign hold_o   = (state == ST_CONV);
  assign acq_o    = en_q & (state == ST_IDLE);
  assign res_hi_o = res[RES_W-1:LO_W];
  assign res_lo_o = res[LO_W-1:0];
  assign flag_o   = flag_q;
  assign irq_o    = flag_q & irq_en_i;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W = 10,
  parameter int LO_W  = 8
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             ctrl_wr_i,
  input logic             ctrl_en_i,
  input logic             ctrl_go_i,
  input logic             en_q,
  input logic             go_o,
  input logic             acq_o,
  input logic             hold_o,
  input logic             flag_o,
  input logic [RES_W-1:0] trial_o,
  input logic [RES_W-LO_W-1:0] res_hi_o,
  input logic [LO_W-1:0]  res_lo_o
);
  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

  AST_START_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(go_o) |-> (trial_o == MSB) && hold_o && !acq_o); // R3

  AST_NO_START_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_wr_i && ctrl_en_i && ctrl_go_i && !en_q |=> !go_o); // R4

  AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable({res_hi_o, res_lo_o}) |-> flag_o && !go_o); // R6

  AST_FLAG_FROM_CONV: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(go_o)); // R8

  AST_ABORT_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_wr_i && ctrl_en_i && !ctrl_go_i && go_o |=>
      !go_o && $stable({res_hi_o, res_lo_o}) && !$rose(flag_o)); // R9

  AST_ABORT_NO_ACQ: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_wr_i && ctrl_en_i && !ctrl_go_i && go_o |=> !acq_o); // R10

  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_wr_i && !ctrl_en_i |=> !go_o && !acq_o && $stable({res_hi_o, res_lo_o})); // R11
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W), .LO_W(LO_W)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .ctrl_wr_i(ctrl_wr_i), .ctrl_en_i(ctrl_en_i),
  .ctrl_go_i(ctrl_go_i), .en_q(en_q), .go_o(go_o), .acq_o(acq_o),
  .hold_o(hold_o), .flag_o(flag_o), .trial_o(trial_o),
  .res_hi_o(res_hi_o), .res_lo_o(res_lo_o)
);

// File: tb/sar_seq_tb.sv
`timescale 1ns/1ps
module sar_seq_tb;
  logic       clk, rst_n, rc_clk, ctrl_wr, ctrl_en, ctrl_go, irq_en, flag_clr, comp;
  logic [2:0] clk_sel;
  logic       go_o, acq_o, hold_o, flag_o, irq_o;
  logic [9:0] trial_o;
  logic [1:0] res_hi_o;
  logic [7:0] res_lo_o;
  int         vin;
  int         n_chk, n_fail;
  bit         wd_hit;

  sar_seq u_dut (
    .clk(clk), .rst_n(rst_n), .rc_clk_i(rc_clk), .ctrl_wr_i(ctrl_wr),
    .ctrl_en_i(ctrl_en), .ctrl_go_i(ctrl_go), .clk_sel_i(clk_sel),
    .irq_en_i(irq_en), .flag_clr_i(flag_clr), .comp_i(comp), .go_o(go_o),
    .acq_o(acq_o), .hold_o(hold_o), .trial_o(trial_o), .res_hi_o(res_hi_o),
    .res_lo_o(res_lo_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ideal comparator: input at or above the trial code
  assign comp = (vin >= int'(trial_o));

  // slow RC clock: toggles every 5 falling system edges
  int rc_div;
  initial begin rc_clk = 1'b0; rc_div = 0; end
  always @(negedge clk) begin
    rc_div++;
    if (rc_div == 5) begin rc_div = 0; rc_clk = ~rc_clk; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_state, m_cnt, m_tad, m_ptr, m_trial, m_res, m_sel;
  bit m_en, m_flag, rs0, rs1, r0, r1, r2;

  function automatic int div_of(input int sel);
    case (sel)
      0: return 2;   4: return 4;   1: return 8;
      5: return 16;  2: return 32;  6: return 64;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_tad = 0; m_ptr = 9; m_trial = 'h200;
      m_res = 0; m_sel = 0; m_en = 0; m_flag = 0;
      rs0 = 0; rs1 = 0; r0 = 0; r1 = 0; r2 = 0;
    end else begin
      if (rs1) begin
        bit rct, tick, kill, start, abort, clr, done;
        int old_state;
        rct   = r1 && !r2;
        r2 = r1; r1 = r0; r0 = rc_clk;
        old_state = m_state;
        if (div_of(m_sel) == 0) tick = (m_state != 0) && rct;
        else                    tick = (m_state != 0) && (m_cnt == div_of(m_sel) - 1);
        kill  = ctrl_wr && !ctrl_en;
        start = ctrl_wr && ctrl_en && ctrl_go && m_en && m_state == 0;
        abort = ctrl_wr && ctrl_en && !ctrl_go && m_state == 1;
        clr   = start || abort || kill;
        done  = 0;
        if (clr) tick = 0;
        if (kill) m_state = 0;
        else if (abort) begin m_state = 2; m_tad = 0; end
        else if (start) begin
          m_state = 1; m_tad = 0; m_trial = 'h200; m_ptr = 9; m_sel = clk_sel;
        end else if (tick) begin
          if (m_state == 1) begin
            if (m_tad >= 1) begin
              if (!(vin >= m_trial)) m_trial = m_trial & ~(1 << m_ptr);
              if (m_ptr > 0) m_trial = m_trial | (1 << (m_ptr - 1));
              m_ptr--;
            end
            if (m_tad == 10) begin m_state = 0; done = 1; m_res = m_trial; end
            else m_tad++;
          end else if (m_state == 2) begin
            if (m_tad == 1) m_state = 0; else m_tad++;
          end
        end
        if (clr) m_cnt = 0;
        else if (old_state != 0) m_cnt = (m_cnt == div_of(m_sel) - 1) ? 0 : m_cnt + 1;
        if (done) m_flag = 1; else if (flag_clr) m_flag = 0;
        if (ctrl_wr) m_en = ctrl_en;
      end
      rs1 = rs0; rs0 = 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !wd_hit) begin
      chk(go_o == (m_state == 1), "R3 go_o", go_o, m_state == 1);
      chk(hold_o == (m_state == 1), "R3 hold_o", hold_o, m_state == 1);
      chk(acq_o == (m_en && m_state == 0), "R10 acq_o", acq_o, m_en && m_state == 0);
      chk(int'(trial_o) == m_trial, "R5 trial_o", trial_o, m_trial);
      chk({res_hi_o, res_lo_o} == 10'(m_res), "R7 result", {res_hi_o, res_lo_o}, m_res);
      chk(flag_o == m_flag, "R8 flag_o", flag_o, m_flag);
      chk(irq_o == (m_flag && irq_en), "R8 irq_o", irq_o, m_flag && irq_en);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input bit en, input bit go);
    @(negedge clk); #1;
    ctrl_wr = 1; ctrl_en = en; ctrl_go = go;
    @(negedge clk); #1;
    ctrl_wr = 0;
  endtask

  task automatic wait_end(output int n);
    n = 0;
    while (go_o && n < 5000) begin @(negedge clk); n++; end
    #1;
  endtask

  task automatic convert(input logic [2:0] sel, input int v, input int exp_cyc);
    int n;
    clk_sel = sel; vin = v;
    wr(1, 1);
    chk(go_o == 1, "R3 start", go_o, 1);
    wait_end(n);
    if (exp_cyc > 0) chk(n == exp_cyc, "R2 length", n, exp_cyc);
    chk({res_hi_o, res_lo_o} == 10'(v), "R6 result", {res_hi_o, res_lo_o}, v);
    chk(res_hi_o == 2'(v >> 8), "R7 high part", res_hi_o, v >> 8);
    chk(flag_o == 1, "R6 flag", flag_o, 1);
    chk(acq_o == 1, "R6 acq back", acq_o, 1);
  endtask

  task automatic run_tests();
    int n;
    logic [9:0] prev;
    repeat (4) @(negedge clk);
    #1;
    chk(go_o == 0 && hold_o == 0 && acq_o == 0, "R1 control", {go_o, hold_o, acq_o}, 0);
    chk(flag_o == 0 && irq_o == 0, "R1 flag", {flag_o, irq_o}, 0);
    chk({res_hi_o, res_lo_o} == 0 && trial_o == 10'h200, "R1 regs", trial_o, 'h200);

    wr(1, 1);
    chk(go_o == 0, "R4 no start on enable write", go_o, 0);
    chk(acq_o == 1, "R4 enabled", acq_o, 1);

    convert(3'b000, 'h2A5, 22);
    convert(3'b100, 'h3FF, 44);
    convert(3'b001, 'h000, 88);
    convert(3'b101, 'h155, 176);
    convert(3'b010, 'h200, 352);
    convert(3'b110, 'h1FF, 704);
    convert(3'b011, 'h1C3, 0);
    convert(3'b111, 'h0AA, 0);

    // R12: select captured at start
    clk_sel = 3'b000; vin = 'h123;
    wr(1, 1);
    clk_sel = 3'b110;
    wait_end(n);
    chk(n == 22, "R12 latched select", n, 22);

    // R8: interrupt and clear
    irq_en = 1;
    @(negedge clk); #1;
    chk(irq_o == 1, "R8 irq", irq_o, 1);
    flag_clr = 1; @(negedge clk); #1; flag_clr = 0;
    chk(flag_o == 0 && irq_o == 0, "R8 cleared", flag_o, 0);

    // R9/R10: abort then recovery
    prev = {res_hi_o, res_lo_o};
    clk_sel = 3'b001; vin = 'h3C0;
    wr(1, 1);
    repeat (30) @(negedge clk);
    wr(1, 0);
    chk(go_o == 0, "R9 abort go", go_o, 0);
    chk({res_hi_o, res_lo_o} == prev, "R9 result kept", {res_hi_o, res_lo_o}, prev);
    chk(flag_o == 0, "R9 flag kept", flag_o, 0);
    chk(acq_o == 0, "R10 no acq", acq_o, 0);
    wr(1, 1);
    chk(go_o == 0, "R10 start ignored", go_o, 0);
    n = 0;
    while (!acq_o && n < 100) begin @(negedge clk); n++; end
    chk(acq_o == 1 && n < 20, "R10 acq resumes", n, 16);

    // R11: disable mid-conversion
    prev = {res_hi_o, res_lo_o};
    clk_sel = 3'b101; vin = 'h0F0;
    wr(1, 1);
    repeat (20) @(negedge clk);
    wr(0, 0);
    chk(go_o == 0 && acq_o == 0, "R11 stopped", {go_o, acq_o}, 0);
    repeat (40) @(negedge clk);
    #1;
    chk({res_hi_o, res_lo_o} == prev, "R11 result kept", {res_hi_o, res_lo_o}, prev);
    wr(1, 0);
    convert(3'b000, 'h301, 22);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; wd_hit = 0; vin = 0;
    ctrl_wr = 0; ctrl_en = 0; ctrl_go = 0; clk_sel = 0; irq_en = 0; flag_clr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    fork
      run_tests();
      begin repeat (150000) @(posedge clk); wd_hit = 1; end
    join_any
    disable fork;
    if (wd_hit) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule